// File: doc/BRIEF.md
# DRAM Refresh Pacer with Fine-Granularity Modes

This block paces REFRESH commands for a DRAM controller. From a base refresh interval, a granularity select (normal, double-rate or quad-rate refresh) and a high-temperature flag, it derives the spacing between refresh obligations. It keeps a count of refreshes that are owed, so the command scheduler can postpone them while other traffic is pending. It raises an urgent flag once the postponement budget of eight is used up. The caller closes open rows, issues the REFRESH and answers the request with a one-cycle grant.

After each accepted grant, the block holds a busy output for the refresh cycle time of the selected granularity. The temperature flag shortens the interval but never changes the busy time. While busy, the request is withdrawn and further grants are ignored.

Top module: `refresh_pacer`

## Requirements
- R1: While reset is held and in the first cycle after it, the owed count is 0 and ref_req, ref_urgent and busy are low.
- R2: The interval in cycles is base_interval shifted right by S, where S is 0 for gran_sel=0 (1x), 1 for gran_sel=1 (2x) and 2 for gran_sel=2 or 3 (4x), plus 1 more when hot is set. A shifted value of 0 is treated as 1. With no grants, the owed count equals floor(n / interval) after n clock edges following reset release, up to the cap of R6.
- R3: hot halves the interval in every granularity, 1x included.
- R4: ref_req is high exactly when the owed count is nonzero and busy is low.
- R5: ref_urgent is high exactly when the owed count has reached 8.
- R6: The owed count saturates at 8. An interval end that arrives at 8 is absorbed.
- R7: A grant taken while ref_req is high lowers the owed count by one. busy then rises on the next edge and stays high for exactly cycle_1x, cycle_2x or cycle_4x cycles, chosen by gran_sel alone, with 3 treated as 4x. hot does not affect the choice.
- R8: A grant presented while ref_req is low has no effect: neither the owed count nor the busy time changes.
- R9: A grant accepted on the same edge as an interval end leaves the owed count unchanged, and busy still starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gran_sel | input | 2 | Refresh granularity: 0=1x, 1=2x, 2 or 3=4x |
| hot | input | 1 | High-temperature flag, halves the interval |
| base_interval | input | IW | Base refresh interval in cycles |
| cycle_1x | input | TW | Refresh busy time in 1x mode |
| cycle_2x | input | TW | Refresh busy time in 2x mode |
| cycle_4x | input | TW | Refresh busy time in 4x mode |
| ref_grant | input | 1 | One-cycle grant from the command scheduler |
| ref_req | output | 1 | Refresh requested |
| ref_urgent | output | 1 | Postponement budget exhausted |
| busy | output | 1 | Refresh in progress |
| owed | output | CW | Number of refreshes owed |

## Verification
The owed count rises on the edge that ends each interval, so it is due after edge k·interval counted from reset release. The bench keeps an edge counter and samples one time unit after each edge: once on the last edge before an interval end and once on the edge itself. busy is due one edge after the grant edge, and the bench counts its high cycles until it falls, comparing that count with the busy time of the mode. Grants are placed so that each busy window finishes before the next interval end, except in the case that deliberately lands a grant on an interval-end edge.

// File: rtl/rfp_pkg.sv
// Shared types for the refresh pacer.
// Assumes: granularity code 3 is treated the same as 4x.
package rfp_pkg;
    typedef enum logic [1:0] {
        GRAN_1X  = 2'd0,
        GRAN_2X  = 2'd1,
        GRAN_4X  = 2'd2,
        GRAN_4XB = 2'd3
    } gran_e;

    // Right-shift applied to the base interval for a granularity and temperature.
    function automatic logic [1:0] ivl_shift(input gran_e g, input logic hot);
        logic [1:0] s;
        case (g)
            GRAN_1X: s = 2'd0;
            GRAN_2X: s = 2'd1;
            default: s = 2'd2;
        endcase
        return s + {1'b0, hot};
    endfunction
endpackage

// File: rtl/rfp_tick_gen.sv
// Interval tick generator: pulses tick once per scaled refresh interval.
// Assumes: interval is base >> (granularity shift + hot), floored at 1.
// A counter above a shrunken interval is reloaded at once.
module rfp_tick_gen
    import rfp_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  gran_e         gran,
    input  logic          hot,
    input  logic [IW-1:0] base,
    output logic          tick
);
    logic [IW-1:0] shifted;
    logic [IW-1:0] ivl;
    logic [IW-1:0] cnt;

    // Scaled interval with a floor of one cycle.
    always_comb begin
        shifted = base >> ivl_shift(gran, hot);
        ivl     = (shifted == '0) ? IW'(1) : shifted;
    end

    assign tick = (cnt == '0);

    // Down-counter reloaded at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= ivl - IW'(1);
        else if (tick)        cnt <= ivl - IW'(1);
        else if (cnt >= ivl)  cnt <= ivl - IW'(1);
        else                  cnt <= cnt - IW'(1);
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ivl > IW'(1) && $stable(ivl)) |=> !tick); // R2
endmodule

// File: rtl/rfp_owed_ctr.sv
// Owed-refresh ledger: counts interval ticks up and accepted grants down.
// Assumes: the grant is honoured only while a request is shown; the count
// saturates at LIMIT, and the request is withheld while busy.
module rfp_owed_ctr #(
    parameter int LIMIT = 8,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          grant,
    input  logic          busy,
    output logic [CW-1:0] owed,
    output logic          req,
    output logic          urgent,
    output logic          accept
);
    localparam logic [CW-1:0] CAP = CW'(LIMIT);

    assign req    = (owed != '0) && !busy;
    assign urgent = (owed == CAP);
    assign accept = grant && req;

    // Up on tick (saturating), down on accepted grant, both cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else if (tick && !accept) begin
            if (owed != CAP) owed <= owed + CW'(1);
        end else if (accept && !tick) begin
            owed <= owed - CW'(1);
        end
    end

    AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= CAP); // R6
    AST_GRANT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !req && !tick) |=> $stable(owed)); // R8
    AST_ACCEPT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !tick) |=> owed == $past(owed) - CW'(1)); // R7
endmodule

// File: rtl/rfp_busy_timer.sv
// Refresh busy timer: holds busy for the cycle time of the current mode.
// Assumes: start only arrives while the timer is idle; hot plays no part.
module rfp_busy_timer
    import rfp_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  gran_e         gran,
    input  logic [TW-1:0] t1x,
    input  logic [TW-1:0] t2x,
    input  logic [TW-1:0] t4x,
    output logic          busy
);
    logic [TW-1:0] load_val;
    logic [TW-1:0] remain;

    // Busy time picked by granularity only.
    always_comb begin
        case (gran)
            GRAN_1X: load_val = t1x;
            GRAN_2X: load_val = t2x;
            default: load_val = t4x;
        endcase
    end

    assign busy = (remain != '0);

    // Load on start, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)     remain <= '0;
        else if (start) remain <= load_val;
        else if (busy)  remain <= remain - TW'(1);
    end

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R7
    AST_BUSY_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> remain == $past(remain) - TW'(1)); // R7
endmodule

// File: rtl/refresh_pacer.sv
// Refresh pacer top: ties the interval tick, owed ledger and busy timer.
// Assumes: the caller precharges banks before answering ref_req with a
// single-cycle ref_grant; configuration is held steady during operation.
module refresh_pacer
    import rfp_pkg::*;
#(
    parameter int IW    = 16,
    parameter int TW    = 10,
    parameter int LIMIT = 8,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    gran_sel,
    input  logic          hot,
    input  logic [IW-1:0] base_interval,
    input  logic [TW-1:0] cycle_1x,
    input  logic [TW-1:0] cycle_2x,
    input  logic [TW-1:0] cycle_4x,
    input  logic          ref_grant,
    output logic          ref_req,
    output logic          ref_urgent,
    output logic          busy,
    output logic [CW-1:0] owed
);
    gran_e gran;
    logic  tick;
    logic  accept;

    assign gran = gran_e'(gran_sel);

    rfp_tick_gen #(.IW(IW)) u_tick (
        .clk(clk), .rst_n(rst_n), .gran(gran), .hot(hot),
        .base(base_interval), .tick(tick)
    );

    rfp_owed_ctr #(.LIMIT(LIMIT)) u_owed (
        .clk(clk), .rst_n(rst_n), .tick(tick), .grant(ref_grant),
        .busy(busy), .owed(owed), .req(ref_req), .urgent(ref_urgent),
        .accept(accept)
    );

    rfp_busy_timer #(.TW(TW)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(accept), .gran(gran),
        .t1x(cycle_1x), .t2x(cycle_2x), .t4x(cycle_4x), .busy(busy)
    );

    AST_REQ_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ref_req); // R4
    AST_URGENT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_urgent) |-> $past(tick)); // R5
endmodule

// File: tb/refresh_pacer_test.sv
module refresh_pacer_test;
    localparam int IW = 16;
    localparam int TW = 10;
    localparam int BASE = 64;
    localparam int T1 = 12;
    localparam int T2 = 8;
    localparam int T4 = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    gran_sel = 2'd0;
    logic          hot = 1'b0;
    logic [IW-1:0] base_interval = IW'(BASE);
    logic [TW-1:0] cycle_1x = TW'(T1);
    logic [TW-1:0] cycle_2x = TW'(T2);
    logic [TW-1:0] cycle_4x = TW'(T4);
    logic          ref_grant = 1'b0;
    logic          ref_req, ref_urgent, busy;
    logic [3:0]    owed;

    int total = 0;
    int bad = 0;
    int n = 0;
    bit done = 0;

    always #2 clk = ~clk;

    refresh_pacer #(.IW(IW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .gran_sel(gran_sel), .hot(hot),
        .base_interval(base_interval), .cycle_1x(cycle_1x),
        .cycle_2x(cycle_2x), .cycle_4x(cycle_4x), .ref_grant(ref_grant),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .busy(busy), .owed(owed)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s gran=%0d hot=%0d edge=%0d actual=%0d expected=%0d",
                     req, gran_sel, hot, n, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        n++;
        #1;
    endtask

    task automatic step_to(input int target);
        while (n < target) step();
    endtask

    task automatic run_config(input int g, input bit h);
        int sh, ivl, tb, bcount;
        sh  = ((g >= 2) ? 2 : g) + (h ? 1 : 0);
        ivl = BASE >> sh;
        tb  = (g == 0) ? T1 : (g == 1) ? T2 : T4;
        gran_sel = 2'(g);
        hot = h;
        rst_n = 1'b0;
        repeat (3) step();
        // R1: reset state while held
        check("R1", {28'd0, owed}, 0);
        check("R1", {29'd0, ref_req, ref_urgent, busy}, 0);
        rst_n = 1'b1;
        n = 0;
        step();
        check("R1", {28'd0, owed}, 0);
        // R2 / R3: first interval end
        step_to(ivl - 1);
        check("R2", {28'd0, owed}, 0);
        check("R4", {31'd0, ref_req}, 0);
        step();
        check(h ? "R3" : "R2", {28'd0, owed}, 1);
        check("R4", {31'd0, ref_req}, 1);
        // R5: budget reached at eighth interval end
        step_to(8 * ivl - 1);
        check("R2", {28'd0, owed}, 7);
        check("R5", {31'd0, ref_urgent}, 0);
        step();
        check("R5", {31'd0, ref_urgent}, 1);
        // R6: saturation
        step_to(10 * ivl);
        check("R6", {28'd0, owed}, 8);
        // R7: grant at edge 10*ivl+1
        ref_grant = 1'b1;
        step();
        ref_grant = 1'b0;
        check("R7", {28'd0, owed}, 7);
        check("R5", {31'd0, ref_urgent}, 0);
        bcount = 0;
        while (busy && bcount < 100) begin
            check("R4", {31'd0, ref_req}, 0);
            bcount++;
            if (n == 10 * ivl + 2) ref_grant = 1'b1;  // R8: sampled while busy
            step();
            ref_grant = 1'b0;
        end
        check("R7", bcount, tb);
        check("R8", {28'd0, owed}, 7);
        check("R8", {31'd0, busy}, 0);
        // R9: grant on interval-end edge
        step_to(11 * ivl - 1);
        ref_grant = 1'b1;
        step();
        ref_grant = 1'b0;
        check("R9", {28'd0, owed}, 7);
        check("R9", {31'd0, busy}, 1);
        repeat (tb) step();
        check("R7", {31'd0, busy}, 0);
    endtask

    initial begin
        for (int g = 0; g < 4; g++) begin
            for (int h = 0; h < 2; h++) begin
                run_config(g, h[0]);
            end
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule